// File: doc/BRIEF.md
# Burst Flash Read Controller

This controller sits on the host side of a flash device whose lower address bits share pins with the data bus. The system presents a read request on a valid/ready port. The request carries a start word address, a mode code and a word count. The words read back leave on a valid-only response port, each with the address it came from. The controller produces the flash control lines itself: chip select, the address latch strobe, output enable, write enable and the flash clock. It also drives and releases the shared address/data lines.

A read is either asynchronous or a clocked burst. An asynchronous read returns one word and keeps the flash clock still for the whole access. Before the first burst after reset, the controller writes its wait-state count to the device's configuration register, once. It then runs bursts with a flash clock at half the system clock rate. A burst can wrap inside an aligned block of 8, 16 or 32 words, or it can run on linearly. Access times are counted in system clock cycles, set by parameters.

Top module: `bfr_ctrl`

## Requirements
- R1: After reset, chip select, address latch strobe, output enable and write enable are high, the flash clock is low, the host does not drive the shared lines, rsp_valid is low and req_ready is high for an idle asynchronous request.
- R2: An asynchronous read (mode code 0) runs as follows. In cycle 0 after acceptance, chip select and the strobe are low, the address is on the bus and write enable is high. In cycle 1 the strobe rises and the bus is released. Output enable is then low for ASYNC_CYC cycles. Exactly one word is returned whatever the word count. The flash clock stays low throughout.
- R3: Before the first burst, and never again, the controller performs one configuration write. Its address is CFG_ADDR, latched by the strobe. In the following cycle, write enable is low with a data word that carries WAIT_CLKS in bits [3:0] and zeros elsewhere. Asynchronous requests never cause this write.
- R4: A burst starts with chip select and the strobe low and the address on the bus for exactly two system cycles. The flash clock rises once during that time. The strobe rises on the same edge where the flash clock falls.
- R5: During a burst, the flash clock toggles on every system clock edge. Whenever chip select is high, or during asynchronous and configuration accesses, the flash clock is low.
- R6: Flash clock rising edges are counted from the address edge, which is edge 0. Word i is captured on the falling edge that follows rising edge WAIT_CLKS+1+i. It appears on rsp_valid for one cycle after that, so one word arrives every two system cycles.
- R7: Mode codes 2, 3 and 4 wrap the address inside an aligned block of 8, 16 and 32 words. A word count larger than the block keeps wrapping.
- R8: Mode codes 1, 5, 6 and 7 run as continuous bursts. Each address is the previous one plus one, across all address bits.
- R9: On the edge that captures the last word, chip select and output enable go high and the flash clock stops low.
- R10: The host stops driving the shared lines at least one cycle before output enable falls. Output enable is never low while the host drives them. Write enable is low only while output enable is high and chip select is low.
- R11: req_ready is high only while idle. It stays low for a burst request until the configuration write is complete.
- R12: rsp_addr carries the address of the returned word and rsp_data the value sampled from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | AW | Start word address |
| req_mode | input | 3 | 0 asynchronous, 1/5/6/7 continuous, 2/3/4 wrap 8/16/32 |
| req_cnt | input | CW | Number of burst words (at least 1) |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | DW | Returned word |
| rsp_addr | output | AW | Address of the returned word |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_alat_n | output | 1 | Address latch strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_clk | output | 1 | Flash burst clock |
| fl_addr_hi | output | AW-DW | Upper address lines |
| fl_ad_o | output | DW | Shared lines, host-driven value |
| fl_ad_oe | output | 1 | Host drives the shared lines when high |
| fl_ad_i | input | DW | Shared lines, value seen from the flash |

## Verification
The assertions assume that req_cnt is at least 1 for a burst and that request fields are held stable while req_valid waits for req_ready. The bench always drives a count from 1 upward, sets the request fields at the same instant as req_valid, and holds them until the accepting edge. The flash model returns data only from the address it latched itself. A word that the controller samples at the wrong clock or from the wrong address therefore shows up as a wrong data value.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
   localparam logic [2:0] MODE_ASYNC = 3'd0;
   localparam logic [2:0] MODE_W8    = 3'd2;
   localparam logic [2:0] MODE_W16   = 3'd3;
   localparam logic [2:0] MODE_W32   = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_C_ADR,
      ST_C_END,
      ST_A_ADR,
      ST_A_TURN,
      ST_A_WAIT,
      ST_B_ADR,
      ST_B_RUN
   } bfr_state_e;
endpackage

// File: rtl/bfr_addr_step.sv
module bfr_addr_step import bfr_pkg::*; #(
   parameter int AW = 22
) (
   input  logic [AW-1:0] cur,
   input  logic [2:0]    mode,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] wmask [3];
   logic [AW-1:0] mask;
   logic [AW-1:0] inc;

   for (genvar g = 0; g < 3; g++) begin : g_wrap
      assign wmask[g] = AW'((8 << g) - 1);
   end

   always_comb begin
      case (mode)
         MODE_W8:  mask = wmask[0];
         MODE_W16: mask = wmask[1];
         MODE_W32: mask = wmask[2];
         default:  mask = '0;
      endcase
      inc = cur + 1'b1;
      nxt = (mask == '0) ? inc : ((cur & ~mask) | (inc & mask));
   end
endmodule

// File: rtl/bfr_fsm.sv
module bfr_fsm import bfr_pkg::*; #(
   parameter int AW        = 22,
   parameter int DW        = 16,
   parameter int CW        = 8,
   parameter int WAIT_CLKS = 3,
   parameter int ASYNC_CYC = 4,
   parameter logic [AW-1:0] CFG_ADDR = AW'(16'h1A00)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [2:0]    req_mode,
   input  logic [CW-1:0] req_cnt,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic [AW-1:0] rsp_addr,
   output logic          fl_ce_n,
   output logic          fl_alat_n,
   output logic          fl_oe_n,
   output logic          fl_we_n,
   output logic          fl_clk,
   output logic [AW-DW-1:0] fl_addr_hi,
   output logic [DW-1:0] fl_ad_o,
   output logic          fl_ad_oe,
   input  logic [DW-1:0] fl_ad_i,
   output logic [AW-1:0] cur_addr,
   output logic [2:0]    cur_mode,
   input  logic [AW-1:0] nxt_addr
);
   localparam int WCW = $clog2(WAIT_CLKS + 2);
   localparam int ACW = $clog2(ASYNC_CYC + 1);

   bfr_state_e    st;
   logic          cfg_done;
   logic [CW-1:0] left;
   logic [WCW-1:0] rcnt;
   logic [ACW-1:0] acnt;
   logic          is_async;

   assign is_async  = (req_mode == MODE_ASYNC);
   assign req_ready = (st == ST_IDLE) && (cfg_done || is_async);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cfg_done   <= 1'b0;
         fl_ce_n    <= 1'b1;
         fl_alat_n  <= 1'b1;
         fl_oe_n    <= 1'b1;
         fl_we_n    <= 1'b1;
         fl_clk     <= 1'b0;
         fl_ad_oe   <= 1'b0;
         fl_ad_o    <= '0;
         fl_addr_hi <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_addr   <= '0;
         cur_addr   <= '0;
         cur_mode   <= MODE_ASYNC;
         left       <= '0;
         rcnt       <= '0;
         acnt       <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid && req_ready) begin
                  cur_addr   <= req_addr;
                  cur_mode   <= req_mode;
                  left       <= req_cnt;
                  fl_ce_n    <= 1'b0;
                  fl_alat_n  <= 1'b0;
                  fl_ad_oe   <= 1'b1;
                  fl_ad_o    <= req_addr[DW-1:0];
                  fl_addr_hi <= req_addr[AW-1:DW];
                  st         <= is_async ? ST_A_ADR : ST_B_ADR;
               end else if (req_valid && !cfg_done && !is_async) begin
                  fl_ce_n    <= 1'b0;
                  fl_alat_n  <= 1'b0;
                  fl_ad_oe   <= 1'b1;
                  fl_ad_o    <= CFG_ADDR[DW-1:0];
                  fl_addr_hi <= CFG_ADDR[AW-1:DW];
                  st         <= ST_C_ADR;
               end
            end
            ST_C_ADR: begin
               fl_alat_n <= 1'b1;
               fl_we_n   <= 1'b0;
               fl_ad_o   <= DW'(WAIT_CLKS);
               st        <= ST_C_END;
            end
            ST_C_END: begin
               fl_we_n  <= 1'b1;
               fl_ce_n  <= 1'b1;
               fl_ad_oe <= 1'b0;
               cfg_done <= 1'b1;
               st       <= ST_IDLE;
            end
            ST_A_ADR: begin
               fl_alat_n <= 1'b1;
               fl_ad_oe  <= 1'b0;
               st        <= ST_A_TURN;
            end
            ST_A_TURN: begin
               fl_oe_n <= 1'b0;
               acnt    <= '0;
               st      <= ST_A_WAIT;
            end
            ST_A_WAIT: begin
               if (acnt == ACW'(ASYNC_CYC - 1)) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= fl_ad_i;
                  rsp_addr  <= cur_addr;
                  fl_ce_n   <= 1'b1;
                  fl_oe_n   <= 1'b1;
                  st        <= ST_IDLE;
               end else begin
                  acnt <= acnt + 1'b1;
               end
            end
            ST_B_ADR: begin
               if (!fl_clk) begin
                  fl_clk <= 1'b1;
               end else begin
                  fl_clk    <= 1'b0;
                  fl_alat_n <= 1'b1;
                  fl_ad_oe  <= 1'b0;
                  rcnt      <= '0;
                  st        <= ST_B_RUN;
               end
            end
            ST_B_RUN: begin
               if (!fl_clk) begin
                  fl_clk  <= 1'b1;
                  fl_oe_n <= 1'b0;
                  if (rcnt <= WCW'(WAIT_CLKS)) rcnt <= rcnt + 1'b1;
               end else begin
                  fl_clk <= 1'b0;
                  if (rcnt > WCW'(WAIT_CLKS)) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= fl_ad_i;
                     rsp_addr  <= cur_addr;
                     cur_addr  <= nxt_addr;
                     left      <= left - 1'b1;
                     if (left == CW'(1)) begin
                        fl_ce_n <= 1'b1;
                        fl_oe_n <= 1'b1;
                        st      <= ST_IDLE;
                     end
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bfr_ctrl.sv
module bfr_ctrl import bfr_pkg::*; #(
   parameter int AW        = 22,
   parameter int DW        = 16,
   parameter int CW        = 8,
   parameter int WAIT_CLKS = 3,
   parameter int ASYNC_CYC = 4,
   parameter logic [AW-1:0] CFG_ADDR = AW'(16'h1A00)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [2:0]    req_mode,
   input  logic [CW-1:0] req_cnt,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic [AW-1:0] rsp_addr,
   output logic          fl_ce_n,
   output logic          fl_alat_n,
   output logic          fl_oe_n,
   output logic          fl_we_n,
   output logic          fl_clk,
   output logic [AW-DW-1:0] fl_addr_hi,
   output logic [DW-1:0] fl_ad_o,
   output logic          fl_ad_oe,
   input  logic [DW-1:0] fl_ad_i
);
   if (AW <= DW || AW < 6) begin : g_bad_aw
      $error("bfr_ctrl: AW must exceed DW and be at least 6");
   end
   if (DW < 4) begin : g_bad_dw
      $error("bfr_ctrl: DW must hold the 4-bit wait field");
   end
   if (WAIT_CLKS < 1 || WAIT_CLKS > 15) begin : g_bad_wait
      $error("bfr_ctrl: WAIT_CLKS must be 1..15");
   end
   if (ASYNC_CYC < 1 || CW < 1) begin : g_bad_cyc
      $error("bfr_ctrl: ASYNC_CYC and CW must be at least 1");
   end

   logic [AW-1:0] cur_addr;
   logic [AW-1:0] nxt_addr;
   logic [2:0]    cur_mode;

   bfr_addr_step #(.AW(AW)) u_step (
      .cur  (cur_addr),
      .mode (cur_mode),
      .nxt  (nxt_addr)
   );

   bfr_fsm #(
      .AW(AW), .DW(DW), .CW(CW), .WAIT_CLKS(WAIT_CLKS),
      .ASYNC_CYC(ASYNC_CYC), .CFG_ADDR(CFG_ADDR)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_mode(req_mode), .req_cnt(req_cnt),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr),
      .fl_ce_n(fl_ce_n), .fl_alat_n(fl_alat_n), .fl_oe_n(fl_oe_n),
      .fl_we_n(fl_we_n), .fl_clk(fl_clk), .fl_addr_hi(fl_addr_hi),
      .fl_ad_o(fl_ad_o), .fl_ad_oe(fl_ad_oe), .fl_ad_i(fl_ad_i),
      .cur_addr(cur_addr), .cur_mode(cur_mode), .nxt_addr(nxt_addr)
   );
endmodule

// File: rtl/bfr_chk.sv
module bfr_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic fl_ce_n,
   input logic fl_alat_n,
   input logic fl_oe_n,
   input logic fl_we_n,
   input logic fl_clk,
   input logic fl_ad_oe
);
   AST_CLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      fl_ce_n |-> !fl_clk); // R5

   AST_ALAT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_clk && !fl_alat_n) |=> (fl_alat_n && !fl_clk)); // R4

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_ad_oe); // R10

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_oe_n) |-> $past(!fl_ad_oe)); // R10

   AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_ad_oe)); // R3

   AST_RSP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!fl_ce_n && !fl_oe_n)); // R12

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> fl_ce_n); // R11
endmodule

bind bfr_ctrl bfr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .fl_ce_n(fl_ce_n), .fl_alat_n(fl_alat_n), .fl_oe_n(fl_oe_n),
   .fl_we_n(fl_we_n), .fl_clk(fl_clk), .fl_ad_oe(fl_ad_oe)
);

// File: tb/tb_bfr_ctrl.sv
module tb_bfr_ctrl;
   localparam int AW = 22, DW = 16, CW = 8, W = 3, AC = 4;
   localparam logic [AW-1:0] CFGA = 22'h01A00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_mode = '0;
   logic [CW-1:0] req_cnt = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] rsp_addr;
   logic fl_ce_n, fl_alat_n, fl_oe_n, fl_we_n, fl_clk, fl_ad_oe;
   logic [AW-DW-1:0] fl_addr_hi;
   logic [DW-1:0] fl_ad_o, fl_ad_i;

   bfr_ctrl #(.AW(AW), .DW(DW), .CW(CW), .WAIT_CLKS(W), .ASYNC_CYC(AC),
              .CFG_ADDR(CFGA)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_mode(req_mode), .req_cnt(req_cnt),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr),
      .fl_ce_n(fl_ce_n), .fl_alat_n(fl_alat_n), .fl_oe_n(fl_oe_n),
      .fl_we_n(fl_we_n), .fl_clk(fl_clk), .fl_addr_hi(fl_addr_hi),
      .fl_ad_o(fl_ad_o), .fl_ad_oe(fl_ad_oe), .fl_ad_i(fl_ad_i));

   int checks = 0, errors = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] mem(input logic [21:0] a);
      return a[15:0] ^ {a[21:16], a[21:16], 4'h9} ^ 16'h3C5A;
   endfunction

   function automatic logic [21:0] seq_addr(input logic [21:0] base, input logic [2:0] m, input int i);
      int len, b;
      b = int'(base);
      case (m)
         3'd2: len = 8;
         3'd3: len = 16;
         3'd4: len = 32;
         default: len = 0;
      endcase
      if (len == 0) return 22'(b + i);
      return 22'((b - b % len) + ((b % len + i) % len));
   endfunction

   // behavioural flash device
   logic [21:0] lat = '0;
   logic [21:0] bbase = '0;
   logic [15:0] bdata = 16'hBAD0;
   logic        bursting = 1'b0;
   logic        pclk = 1'b0;
   logic [2:0]  fmode = '0;
   int          jedge = 0;
   int          cfg_cnt = 0;
   logic [15:0] cfg_val = '0;
   logic [21:0] cfg_at = '0;

   always @(negedge clk) begin
      if (fl_ce_n) bursting = 1'b0;
      if (!fl_ce_n && !fl_alat_n) lat = {fl_addr_hi, fl_ad_o};
      if (!fl_ce_n && !fl_we_n) begin
         cfg_cnt++;
         cfg_val = fl_ad_o;
         cfg_at  = lat;
      end
      if (!fl_ce_n && fl_clk && !pclk) begin
         if (!fl_alat_n) begin
            bursting = 1'b1;
            bbase = lat;
            jedge = 0;
            bdata = 16'hBAD0;
         end else if (bursting) begin
            jedge++;
            if (jedge >= W + 1) bdata = mem(seq_addr(bbase, fmode, jedge - W - 1));
         end
      end
      pclk = fl_clk;
   end

   assign fl_ad_i = bursting ? bdata : (!fl_oe_n ? mem(lat) : 16'hDEAD);

   logic cfg_seen = 1'b0;

   task automatic run_req(input logic [21:0] a, input logic [2:0] m, input int n);
      int kl, got, guard, idx;
      logic is_async;
      logic [21:0] ea;
      is_async = (m == 3'd0);
      fmode = m;
      got = 0;
      @(negedge clk);
      req_addr = a; req_mode = m; req_cnt = 8'(n); req_valid = 1'b1;
      #1;
      if (!is_async && !cfg_seen)
         chk("R11 ready low before configuration", {31'd0, req_ready}, 32'd0);
      guard = 0;
      while (!req_ready && guard < 20) begin
         @(negedge clk); #1; guard++;
      end
      if (!is_async && !cfg_seen) begin
         chk("R3 config write count", cfg_cnt, 1);
         chk("R3 config data", {16'd0, cfg_val}, W);
         chk("R3 config address", {10'd0, cfg_at}, {10'd0, CFGA});
         cfg_seen = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      kl = is_async ? AC + 2 : 2 * W + 2 + 2 * n;
      for (int k = 0; k <= kl; k++) begin
         chk("R9 chip select", {31'd0, fl_ce_n}, (k == kl) ? 1 : 0);
         chk("R10 write enable high in reads", {31'd0, fl_we_n}, 1);
         chk("R11 ready while busy", {31'd0, req_ready}, (k == kl) ? 1 : 0);
         if (k == 0) begin
            chk("R4 low address on bus", {16'd0, fl_ad_o}, {16'd0, a[15:0]});
            chk("R4 high address lines", {26'd0, fl_addr_hi}, {26'd0, a[21:16]});
         end
         if (is_async) begin
            chk("R2 clock still", {31'd0, fl_clk}, 0);
            chk("R2 strobe", {31'd0, fl_alat_n}, (k == 0) ? 0 : 1);
            chk("R10 bus drive", {31'd0, fl_ad_oe}, (k == 0) ? 1 : 0);
            chk("R2 output enable", {31'd0, fl_oe_n}, (k >= 2 && k < kl) ? 0 : 1);
            chk("R2 single response", {31'd0, rsp_valid}, (k == kl) ? 1 : 0);
            if (rsp_valid) begin
               got++;
               chk("R12 async address", {10'd0, rsp_addr}, {10'd0, a});
               chk("R12 async data", {16'd0, rsp_data}, {16'd0, mem(a)});
            end
         end else begin
            chk("R5 flash clock", {31'd0, fl_clk},
                (k == 1 || (k >= 3 && k < kl && (k % 2) == 1)) ? 1 : 0);
            chk("R4 strobe two cycles", {31'd0, fl_alat_n}, (k < 2) ? 0 : 1);
            chk("R10 bus drive", {31'd0, fl_ad_oe}, (k < 2) ? 1 : 0);
            chk("R10 output enable after release", {31'd0, fl_oe_n}, (k >= 3 && k < kl) ? 0 : 1);
            chk("R6 word timing", {31'd0, rsp_valid},
                (k >= 2 * W + 4 && ((k - (2 * W + 4)) % 2) == 0) ? 1 : 0);
            if (rsp_valid) begin
               idx = (k - (2 * W + 4)) / 2;
               ea = seq_addr(a, m, idx);
               got++;
               chk((m == 3'd2 || m == 3'd3 || m == 3'd4) ? "R7 wrap address" : "R8 linear address",
                   {10'd0, rsp_addr}, {10'd0, ea});
               chk("R12 burst data", {16'd0, rsp_data}, {16'd0, mem(ea)});
            end
         end
         @(negedge clk);
      end
      chk(is_async ? "R2 word count" : "R6 word count", got, is_async ? 1 : n);
      chk("R9 clock stopped after end", {31'd0, fl_clk}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 chip select", {31'd0, fl_ce_n}, 1);
      chk("R1 strobe", {31'd0, fl_alat_n}, 1);
      chk("R1 output enable", {31'd0, fl_oe_n}, 1);
      chk("R1 write enable", {31'd0, fl_we_n}, 1);
      chk("R1 clock", {31'd0, fl_clk}, 0);
      chk("R1 bus released", {31'd0, fl_ad_oe}, 0);
      chk("R1 no response", {31'd0, rsp_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 ready", {31'd0, req_ready}, 1);

      run_req(22'h12345, 3'd0, 5);
      chk("R3 no config on async", cfg_cnt, 0);
      run_req(22'h00105, 3'd2, 12);
      run_req(22'h2ABCD, 3'd3, 20);
      run_req(22'h0401C, 3'd4, 6);
      run_req(22'h0FFFE, 3'd1, 5);
      run_req(22'h00010, 3'd7, 3);
      run_req(22'h3FFFFF, 3'd0, 1);
      chk("R3 config written once", cfg_cnt, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule